// File: doc/BRIEF.md
# PWM Dead-Band Generator

This block sits between a PWM action stage and the gate drivers of one half-bridge leg. It receives two PWM waveforms, A and B, and produces two outputs with dead time inserted, so that the upper and lower switches are never driven on together. A source selector decides which input feeds the rising-edge delay and which feeds the falling-edge delay. The delayed signals can each be replaced by the undelayed input, and each output can be inverted.

The rising and falling delay counts each have an active copy, which the delay logic uses, and a shadow copy, which register writes reach. In shadow operation the active copy is refreshed on a counter-zero strobe, a counter-period strobe, either of them, or never. In immediate operation a write lands in both copies at once. Configuration goes through a small write-only register port. Every output is registered, so any change at the inputs reaches the outputs after at least one clock.

Register map (word address on `bus_addr`): 0 is control, 1 is the rising delay, and 2 is the falling delay. The delay value sits in bits [9:0] of the write data.

Top module: `pwm_deadband`

## Requirements
- R1: While `rst` is high, and after it is released, both outputs are 0. All control fields are 0, both delays are 0 in the active and shadow copies, and the block starts in bypass.
- R2: With output mode 00 (control bits [3:2]), `pwm_a_out` equals `pwm_a_in` and `pwm_b_out` equals `pwm_b_in` one clock later. The input-mode and polarity fields have no effect in this mode.
- R3: In the rising-delay path with active delay D, an input that rises and stays high gives an output that rises D+1 clocks after the input. A falling input gives an output that falls after 1 clock. D=0 gives a plain one-clock register stage.
- R4: The falling-delay path mirrors R3. Its output falls D+1 clocks after the input falls, and it rises 1 clock after the input rises.
- R5: A high pulse of W clocks with W <= D produces no pulse at the rising-delay output. With W > D it produces a pulse of W-D clocks. The falling-delay path does the same for low pulses.
- R6: Input mode (control bits [1:0]): 00 sends A to both delays, 01 sends B to the rising and A to the falling delay, 10 sends A to the rising and B to the falling delay, and 11 sends B to both.
- R7: Polarity (control bits [5:4]), when output mode is not 00: 00 inverts neither output, 01 inverts only output A, 10 inverts only output B, and 11 inverts both.
- R8: Output mode 01 routes undelayed input A to path A and the falling-delayed signal to path B. Mode 10 routes the rising-delayed signal to path A and undelayed input B to path B. Mode 11 uses both delayed signals.
- R9: In shadow operation a write to a delay address changes only the shadow copy. The active copy takes the old shadow value on the clock edge of a matching strobe. Load mode codes are 00 for counter zero, 01 for counter period and 10 for either. The rising-delay load mode is control bits [7:6] and the falling-delay load mode is bits [9:8].
- R10: Load mode code 11 freezes the active copy, and no strobe changes it.
- R11: When the immediate bit is 1 (bit 10 for the rising delay, bit 11 for the falling delay), a write sets both the active and shadow copies on that edge, and the load mode has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_wr | input | 1 | Register write strobe |
| bus_addr | input | AW (2) | Register word address |
| bus_wdata | input | DATA_W (12) | Register write data |
| cnt_zero | input | 1 | Time-base counter equals zero strobe |
| cnt_period | input | 1 | Time-base counter equals period strobe |
| pwm_a_in | input | 1 | PWM input A |
| pwm_b_in | input | 1 | PWM input B |
| pwm_a_out | output | 1 | Output A with dead band applied |
| pwm_b_out | output | 1 | Output B with dead band applied |

## Verification
Each output value is due one clock after the inputs, configuration and active delays that produce it. A delayed edge therefore shows up D+1 clocks after the input edge. A register write or a load strobe changes the behaviour from the next edge on. The reference model in the bench takes the same sampled inputs at each rising edge, forms the expected output for that edge, and applies writes and loads afterwards. Outputs are compared at the following falling edge. Directed checks count falling edges from an input edge to the output edge, so that the active delay after a write, a strobe or a freeze is read through the ports.

// File: rtl/pwm_db_pkg.sv
package pwm_db_pkg;

  typedef enum logic [1:0] {
    LD_ZERO   = 2'b00,
    LD_PRD    = 2'b01,
    LD_EITHER = 2'b10,
    LD_FREEZE = 2'b11
  } load_mode_e;

  // control word, MSB first: bits 11..0
  typedef struct packed {
    logic       fall_imm;   // 11
    logic       rise_imm;   // 10
    load_mode_e fall_ld;    // 9:8
    load_mode_e rise_ld;    // 7:6
    logic [1:0] pol;        // 5:4
    logic [1:0] out_mode;   // 3:2
    logic [1:0] in_mode;    // 1:0
  } db_ctl_t;

  localparam int CTL_W = $bits(db_ctl_t);

  localparam logic [1:0] ADDR_CTL  = 2'd0;
  localparam logic [1:0] ADDR_RISE = 2'd1;
  localparam logic [1:0] ADDR_FALL = 2'd2;

endpackage

// File: rtl/db_edge_delay.sv
// Delays one edge direction by dly clocks; the other edge passes at once.
// ACT_LOW=0 delays rising edges, ACT_LOW=1 delays falling edges.
module db_edge_delay #(
  parameter int DW      = 10,
  parameter bit ACT_LOW = 1'b0
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          din,
  input  logic [DW-1:0] dly,
  output logic          dout
);
  logic          x;
  logic [DW-1:0] run;

  assign x = din ^ ACT_LOW;

  // run = consecutive asserted samples seen before this one (saturating)
  always_ff @(posedge clk) begin
    if (rst || !x) run <= '0;
    else if (run != {DW{1'b1}}) run <= run + 1'b1;
  end

  assign dout = (x && (run >= dly)) ^ ACT_LOW;

  a_r5_run_clears: assert property (@(posedge clk) disable iff (rst)
    !x |=> (run == '0));

endmodule

// File: rtl/db_delay_reg.sv
// Active/shadow pair for one delay count.
module db_delay_reg
  import pwm_db_pkg::*;
#(
  parameter int DW = 10
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          wr_en,
  input  logic [DW-1:0] wr_data,
  input  logic          imm,
  input  load_mode_e    ld_mode,
  input  logic          cnt_zero,
  input  logic          cnt_period,
  output logic [DW-1:0] active
);
  logic [DW-1:0] shadow;
  logic          load;

  always_comb begin
    unique case (ld_mode)
      LD_ZERO:   load = cnt_zero;
      LD_PRD:    load = cnt_period;
      LD_EITHER: load = cnt_zero | cnt_period;
      default:   load = 1'b0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      shadow <= '0;
      active <= '0;
    end else begin
      if (wr_en) shadow <= wr_data;
      if (imm && wr_en) active <= wr_data;
      else if (!imm && load) active <= shadow;
    end
  end

  a_r10_freeze_hold: assert property (@(posedge clk) disable iff (rst)
    (!imm && ld_mode == LD_FREEZE) |=> $stable(active));

  a_r9_load_on_zero: assert property (@(posedge clk) disable iff (rst)
    (!imm && ld_mode == LD_ZERO && cnt_zero) |=> (active == $past(shadow)));

  a_r11_imm_write: assert property (@(posedge clk) disable iff (rst)
    (imm && wr_en) |=> (active == $past(wr_data) && shadow == $past(wr_data)));

endmodule

// File: rtl/pwm_deadband.sv
module pwm_deadband
  import pwm_db_pkg::*;
#(
  parameter int DW     = 10,
  parameter int AW     = 2,
  parameter int DATA_W = CTL_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              bus_wr,
  input  logic [AW-1:0]     bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  input  logic              cnt_zero,
  input  logic              cnt_period,
  input  logic              pwm_a_in,
  input  logic              pwm_b_in,
  output logic              pwm_a_out,
  output logic              pwm_b_out
);
  localparam int NPATH = 2;   // 0: rising-edge path, 1: falling-edge path

  db_ctl_t       ctl;
  logic [DW-1:0] act_dly [NPATH];
  logic          src     [NPATH];
  logic          dly_out [NPATH];
  logic          nxt_a, nxt_b;

  always_ff @(posedge clk) begin
    if (rst) ctl <= '0;
    else if (bus_wr && bus_addr == AW'(ADDR_CTL)) ctl <= db_ctl_t'(bus_wdata[CTL_W-1:0]);
  end

  assign src[0] = ctl.in_mode[0] ? pwm_b_in : pwm_a_in;
  assign src[1] = ctl.in_mode[1] ? pwm_b_in : pwm_a_in;

  for (genvar g = 0; g < NPATH; g++) begin : g_path
    logic wr_hit;
    assign wr_hit = bus_wr && (bus_addr == AW'(ADDR_RISE) + AW'(g));

    db_delay_reg #(.DW(DW)) u_reg (
      .clk       (clk),
      .rst       (rst),
      .wr_en     (wr_hit),
      .wr_data   (bus_wdata[DW-1:0]),
      .imm       ((g == 0) ? ctl.rise_imm : ctl.fall_imm),
      .ld_mode   ((g == 0) ? ctl.rise_ld : ctl.fall_ld),
      .cnt_zero  (cnt_zero),
      .cnt_period(cnt_period),
      .active    (act_dly[g])
    );

    db_edge_delay #(.DW(DW), .ACT_LOW(g == 1)) u_dly (
      .clk (clk),
      .rst (rst),
      .din (src[g]),
      .dly (act_dly[g]),
      .dout(dly_out[g])
    );
  end

  always_comb begin
    if (ctl.out_mode == 2'b00) begin
      nxt_a = pwm_a_in;
      nxt_b = pwm_b_in;
    end else begin
      nxt_a = (ctl.out_mode[1] ? dly_out[0] : pwm_a_in) ^ ctl.pol[0];
      nxt_b = (ctl.out_mode[0] ? dly_out[1] : pwm_b_in) ^ ctl.pol[1];
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      pwm_a_out <= 1'b0;
      pwm_b_out <= 1'b0;
    end else begin
      pwm_a_out <= nxt_a;
      pwm_b_out <= nxt_b;
    end
  end

  a_r2_bypass: assert property (@(posedge clk) disable iff (rst)
    (ctl.out_mode == 2'b00) |=> (pwm_a_out == $past(pwm_a_in) && pwm_b_out == $past(pwm_b_in)));

  a_r3_no_early_rise: assert property (@(posedge clk) disable iff (rst)
    (ctl.out_mode == 2'b11 && ctl.in_mode == 2'b00 && ctl.pol == 2'b00 && !pwm_a_in) |=> !pwm_a_out);

  a_r4_no_early_fall: assert property (@(posedge clk) disable iff (rst)
    (ctl.out_mode == 2'b11 && ctl.in_mode == 2'b00 && ctl.pol == 2'b00 && pwm_a_in) |=> pwm_b_out);

endmodule

// File: tb/sim_pwm_deadband.sv
`timescale 1ns/1ps
module sim_pwm_deadband;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        bus_wr = 1'b0;
  logic [1:0]  bus_addr = '0;
  logic [11:0] bus_wdata = '0;
  logic        cnt_zero = 1'b0, cnt_period = 1'b0;
  logic        a_in = 1'b0, b_in = 1'b0;
  logic        a_out, b_out;

  int checks = 0;
  int errors = 0;
  string cur_req = "R1";

  always #2 clk = ~clk;   // 250 MHz

  pwm_deadband u0 (
    .clk(clk), .rst(rst), .bus_wr(bus_wr), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
    .cnt_zero(cnt_zero), .cnt_period(cnt_period),
    .pwm_a_in(a_in), .pwm_b_in(b_in), .pwm_a_out(a_out), .pwm_b_out(b_out)
  );

  // ---------------- behavioural reference model ----------------
  logic [11:0] m_ctl;
  int  rise_act, rise_sh, fall_act, fall_sh;
  int  hi_len, lo_len;       // consecutive high / low samples of the sources
  bit  exp_a, exp_b, m_valid = 0;

  function automatic bit ld_hit(input logic [1:0] md, input bit z, input bit p);
    return (md == 2'd0 && z) || (md == 2'd1 && p) || (md == 2'd2 && (z || p));
  endfunction

  always @(posedge clk) begin
    bit rs, fs, red, fed;
    if (rst) begin
      m_ctl = '0; rise_act = 0; rise_sh = 0; fall_act = 0; fall_sh = 0;
      hi_len = 0; lo_len = 0; exp_a = 0; exp_b = 0; m_valid = 1;
    end else begin
      rs  = m_ctl[0] ? b_in : a_in;
      fs  = m_ctl[1] ? b_in : a_in;
      red = rs && (hi_len >= rise_act);
      fed = !(!fs && (lo_len >= fall_act));
      if (m_ctl[3:2] == 2'b00) begin
        exp_a = a_in; exp_b = b_in;
      end else begin
        exp_a = (m_ctl[3] ? red : a_in) ^ m_ctl[4];
        exp_b = (m_ctl[2] ? fed : b_in) ^ m_ctl[5];
      end
      hi_len = rs ? ((hi_len < 1023) ? hi_len + 1 : 1023) : 0;
      lo_len = !fs ? ((lo_len < 1023) ? lo_len + 1 : 1023) : 0;
      if (!m_ctl[10] && ld_hit(m_ctl[7:6], cnt_zero, cnt_period)) rise_act = rise_sh;
      if (!m_ctl[11] && ld_hit(m_ctl[9:8], cnt_zero, cnt_period)) fall_act = fall_sh;
      if (bus_wr) begin
        case (bus_addr)
          2'd0: m_ctl = bus_wdata;
          2'd1: begin rise_sh = int'(bus_wdata[9:0]); if (m_ctl[10]) rise_act = rise_sh; end
          2'd2: begin fall_sh = int'(bus_wdata[9:0]); if (m_ctl[11]) fall_act = fall_sh; end
          default: ;
        endcase
      end
    end
  end

  task automatic check(input string req, input int got, input int exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s: got %0d expected %0d at %0t", req, got, exp, $time);
    end
  endtask

  // per-cycle comparison against the model
  always @(negedge clk) begin
    if (m_valid) begin
      check({cur_req, " out_a"}, int'(a_out), int'(exp_a));
      check({cur_req, " out_b"}, int'(b_out), int'(exp_b));
    end
  end

  // ---------------- stimulus helpers ----------------
  task automatic wr_reg(input logic [1:0] ad, input logic [11:0] d);
    @(negedge clk); bus_wr = 1; bus_addr = ad; bus_wdata = d;
    @(negedge clk); bus_wr = 0;
  endtask

  task automatic strobe(input bit z, input bit p);
    @(negedge clk); cnt_zero = z; cnt_period = p;
    @(negedge clk); cnt_zero = 0; cnt_period = 0;
  endtask

  // clocks from A rising to out_a rising (mode 11, in 00, pol 00)
  task automatic meas_rise(output int n);
    @(negedge clk); a_in = 0;
    repeat (3) @(negedge clk);
    a_in = 1; n = 0;
    do begin @(negedge clk); n++; end while (!a_out && n < 2000);
    a_in = 0; repeat (2) @(negedge clk);
  endtask

  // clocks from A falling to out_b falling
  task automatic meas_fall(output int n);
    @(negedge clk); a_in = 1;
    repeat (3) @(negedge clk);
    a_in = 0; n = 0;
    do begin @(negedge clk); n++; end while (b_out && n < 2000);
    repeat (2) @(negedge clk);
  endtask

  // count output-A high cycles produced by a high pulse of w clocks
  task automatic pulse_a(input int w, output int highs);
    @(negedge clk); a_in = 0;
    repeat (2) @(negedge clk);
    highs = 0; a_in = 1;
    for (int i = 0; i < w + 12; i++) begin
      if (i == w) a_in = 0;
      @(negedge clk);
      if (a_out) highs++;
    end
  endtask

  task automatic random_run(input string req, input logic [11:0] ctl, input int n);
    cur_req = req;
    wr_reg(2'd0, ctl);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      if ($urandom % 6 == 0) a_in = ~a_in;
      if ($urandom % 5 == 0) b_in = ~b_in;
      cnt_zero   = ($urandom % 9 == 0);
      cnt_period = ($urandom % 11 == 0);
      bus_wr     = ($urandom % 30 == 0);
      bus_addr   = 2'd1 + 2'($urandom % 2);
      bus_wdata  = 12'($urandom % 8);
    end
    @(negedge clk); bus_wr = 0; cnt_zero = 0; cnt_period = 0;
  endtask

  // ---------------- watchdog ----------------
  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  // ---------------- main sequence ----------------
  initial begin
    int n;
    repeat (3) @(negedge clk);
    check("R1 reset out_a", int'(a_out), 0);
    check("R1 reset out_b", int'(b_out), 0);
    rst = 0;
    @(negedge clk);
    cur_req = "R1";
    check("R1 after release out_a", int'(a_out), 0);

    // R2: bypass, with other fields set to prove they are ignored
    random_run("R2", 12'h033, 200);

    // R11: immediate writes, mode 11
    cur_req = "R11";
    wr_reg(2'd0, 12'hC0C);
    wr_reg(2'd1, 12'd4);
    wr_reg(2'd2, 12'd3);
    meas_rise(n); check("R3/R11 rise latency D=4", n, 5);
    meas_fall(n); check("R4/R11 fall latency D=3", n, 4);
    wr_reg(2'd1, 12'd0);
    meas_rise(n); check("R3 rise latency D=0", n, 1);

    // R5: short pulses swallowed
    cur_req = "R5";
    wr_reg(2'd1, 12'd4);
    pulse_a(4, n); check("R5 pulse W=D swallowed", n, 0);
    pulse_a(2, n); check("R5 pulse W<D swallowed", n, 0);
    pulse_a(7, n); check("R5 pulse W=7 D=4 width", n, 3);

    // R9: shadow operation, rise loads on zero, fall on period
    cur_req = "R9";
    wr_reg(2'd1, 12'd2);
    wr_reg(2'd2, 12'd2);
    wr_reg(2'd0, 12'h10C);
    wr_reg(2'd1, 12'd6);
    meas_rise(n); check("R9 write reaches shadow only", n, 3);
    strobe(0, 1);
    meas_rise(n); check("R9 period strobe ignored in zero mode", n, 3);
    strobe(1, 0);
    meas_rise(n); check("R9 zero strobe loads rise", n, 7);
    wr_reg(2'd2, 12'd5);
    strobe(1, 0);
    meas_fall(n); check("R9 zero strobe ignored in period mode", n, 3);
    strobe(0, 1);
    meas_fall(n); check("R9 period strobe loads fall", n, 6);

    // R10: freeze
    cur_req = "R10";
    wr_reg(2'd0, 12'h0CC);
    wr_reg(2'd1, 12'd9);
    strobe(1, 1);
    strobe(1, 0);
    meas_rise(n); check("R10 frozen rise delay", n, 7);
    wr_reg(2'd0, 12'h08C);
    strobe(0, 1);
    meas_rise(n); check("R9 either mode loads on period", n, 10);

    // R6 / R7 / R8 random runs with shadow loads on either strobe
    random_run("R6 in01", 12'h2AD, 300);
    random_run("R6 in10", 12'h2AE, 300);
    random_run("R6 in11", 12'h2AF, 300);
    random_run("R7 pol01", 12'h29C, 300);
    random_run("R7 pol10", 12'h2AC, 300);
    random_run("R7 pol11", 12'h2BC, 300);
    random_run("R8 out01", 12'h284, 300);
    random_run("R8 out10", 12'h298, 300);
    random_run("R11 imm", 12'hC0D, 300);
    random_run("R2 bypass", 12'h3F3, 200);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule